// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block decides which interrupt a 16550-style UART reports to the processor. It watches five conditions: receive line errors, the receive FIFO filling to its trigger level, the receive FIFO sitting idle while holding data, the transmit holding register becoming empty, and a change on the modem control inputs. Each condition is masked by its own enable. The highest-ranked survivor is reported as a 4-bit identification code, and a single request line is raised whenever any enabled condition is pending.

The serial shifters, the FIFOs and the register decode sit outside this block. They reach it as status levels (receive FIFO level, holding-register-empty flag, modem input levels), event pulses (line errors, FIFO push/pop, baud ticks) and one-cycle access strobes. Each strobe clears the latched source it belongs to. The block also keeps the FIFO control byte's trigger field and the programmable receive-idle duration, and it contains the idle counter that measures that duration in baud ticks.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification code is 4'b0001, the request line is low and all four modem delta bits are zero.
- R2: The request line is high exactly when the identification code differs from 4'b0001, and it is the OR of all enabled pending sources.
- R3: Any bit of `line_err` latches the line-error source (code 4'b0110, highest rank) from the next cycle; an `lsr_rd` strobe with no error in the same cycle clears it.
- R4: The data-available source (code 4'b0100) is reported, with no register delay, while `rx_level` is at or above the threshold held in FIFO control bits [7:4]; a field value of 0 means a threshold of 1.
- R5: With a non-zero idle duration T, a non-empty receive FIFO and no push or pop, the timeout source (code 4'b1100) is set in the cycle after the T-th `baud_tick`; a push or pop restarts the count; `rbr_rd` or an empty FIFO clears it; T = 0 disables it.
- R6: The holding-empty source (code 4'b0010) is latched on a rising edge of `thr_empty`; it is cleared by `thr_wr`, or by `iir_rd` only in a cycle where code 4'b0010 is being reported.
- R7: Modem delta bits are [0] CTS changed, [1] DSR changed, [2] RI fell high-to-low, [3] DCD changed; they stay set until `msr_rd`, and any set bit raises the modem source (code 4'b0000, lowest rank).
- R8: Enable bits are `ien[0]` data-available and timeout, `ien[1]` holding-empty, `ien[2]` line-error, `ien[3]` modem; a disabled source neither drives the request line nor appears in the code, and with `ien` all zero the request line is low.
- R9: On an FIFO control write, `rx_fifo_clr` pulses when bit 1 is set or bit 0 is clear, `tx_fifo_clr` pulses when bit 2 is set or bit 0 is clear, and `dma_sel` takes bit 3 from the next cycle.
- R10: Ranking is line-error, then data-available, then timeout, then holding-empty, then modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 4 | Per-source enable bits |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| tor_wr | input | 1 | Idle-duration register write strobe |
| tor_wdata | input | TOR_W | Idle duration in baud ticks |
| baud_tick | input | 1 | Receive baud tick |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO push event |
| rx_pop | input | 1 | Receive FIFO pop event |
| line_err | input | 4 | Overrun, parity, framing, break event pulses |
| lsr_rd | input | 1 | Line status read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_empty | input | 1 | Transmit holding register empty status |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| cts | input | 1 | Clear-to-send level (synchronised) |
| dsr | input | 1 | Data-set-ready level (synchronised) |
| ri | input | 1 | Ring indicator level (synchronised) |
| dcd | input | 1 | Carrier detect level (synchronised) |
| iir_code | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |
| modem_delta | output | 4 | Latched modem delta bits |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| dma_sel | output | 1 | DMA mode select |

## Verification
The bench keeps the default build, a 5-bit level (FIFO up to 16 entries) and an 8-bit idle duration. At that size every trigger code can be crossed with every fill level from 0 to 16, and all sixteen enable masks can be swept with four sources pending at once. The idle durations 1 to 6 are each run to the exact tick. A zero duration is held for 260 ticks, which is past the counter's wrap point, to show that it stays disabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source slots in rank order: index 0 wins.
  localparam int unsigned NSRC     = 5;
  localparam int unsigned SLOT_LE  = 0;
  localparam int unsigned SLOT_DA  = 1;
  localparam int unsigned SLOT_TO  = 2;
  localparam int unsigned SLOT_HE  = 3;
  localparam int unsigned SLOT_MS  = 4;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_LINE_ERR,
    SRC_DATA_AVAIL,
    SRC_IDLE_TOUT,
    SRC_HOLD_EMPTY,
    SRC_MODEM
  } irq_src_e;

  localparam logic [3:0] ID_NONE  = 4'b0001;
  localparam logic [3:0] ID_LE    = 4'b0110;
  localparam logic [3:0] ID_DA    = 4'b0100;
  localparam logic [3:0] ID_TO    = 4'b1100;
  localparam logic [3:0] ID_HE    = 4'b0010;
  localparam logic [3:0] ID_MS    = 4'b0000;

  function automatic irq_src_e slot_to_src(input int unsigned slot);
    case (slot)
      SLOT_LE: return SRC_LINE_ERR;
      SLOT_DA: return SRC_DATA_AVAIL;
      SLOT_TO: return SRC_IDLE_TOUT;
      SLOT_HE: return SRC_HOLD_EMPTY;
      SLOT_MS: return SRC_MODEM;
      default: return SRC_NONE;
    endcase
  endfunction

  function automatic logic [3:0] src_to_id(input irq_src_e src);
    case (src)
      SRC_LINE_ERR:   return ID_LE;
      SRC_DATA_AVAIL: return ID_DA;
      SRC_IDLE_TOUT:  return ID_TO;
      SRC_HOLD_EMPTY: return ID_HE;
      SRC_MODEM:      return ID_MS;
      default:        return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned TOR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rbr_rd,
  input  logic [TOR_W-1:0] idle_len,
  output logic             tout
);

  logic [TOR_W-1:0] cnt_q, cnt_d;
  logic             tout_q, tout_d;
  logic             fifo_empty;
  logic             fifo_activity;
  logic             len_zero;
  logic [TOR_W-1:0] last_cnt;

  assign fifo_empty    = (rx_level == '0);
  assign fifo_activity = rx_push | rx_pop;
  assign len_zero      = (idle_len == '0);
  assign last_cnt      = idle_len - TOR_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    tout_d = tout_q;
    if (fifo_empty) begin
      cnt_d  = '0;
      tout_d = 1'b0;
    end else begin
      if (fifo_activity) begin
        cnt_d = '0;
      end else if (baud_tick && !tout_q && !len_zero) begin
        if (cnt_q == last_cnt) begin
          cnt_d  = '0;
          tout_d = 1'b1;
        end else begin
          cnt_d = cnt_q + TOR_W'(1);
        end
      end
      if (rbr_rd) begin
        tout_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tout_q <= tout_d;
    end
  end

  assign tout = tout_q;

endmodule

// File: rtl/uart_irq_modem_delta.sv
module uart_irq_modem_delta #(
  parameter int unsigned       NLINE     = 4,
  parameter logic [NLINE-1:0]  FALL_ONLY = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] line_in,
  input  logic             msr_rd,
  output logic [NLINE-1:0] delta
);

  logic [NLINE-1:0] prev_q;
  logic             primed_q;
  logic [NLINE-1:0] delta_q, delta_d;
  logic [NLINE-1:0] event_v;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    if (FALL_ONLY[g]) begin : g_fall
      assign event_v[g] = primed_q & prev_q[g] & ~line_in[g];
    end else begin : g_any
      assign event_v[g] = primed_q & (prev_q[g] ^ line_in[g]);
    end

    always_comb begin
      if (event_v[g]) begin
        delta_d[g] = 1'b1;
      end else if (msr_rd) begin
        delta_d[g] = 1'b0;
      end else begin
        delta_d[g] = delta_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      delta_q  <= '0;
    end else begin
      prev_q   <= line_in;
      primed_q <= 1'b1;
      delta_q  <= delta_d;
    end
  end

  assign delta = delta_q;

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] enable,
  output logic [3:0]      id_code,
  output logic            req,
  output logic            he_reported
);

  logic [NSRC-1:0] live;
  irq_src_e        winner;

  assign live = pend & enable;

  always_comb begin
    winner = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        winner = slot_to_src(i);
      end
    end
  end

  assign id_code     = src_to_id(winner);
  assign req         = |live;
  assign he_reported = (winner == SRC_HOLD_EMPTY);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned TOR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ien,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  input  logic             tor_wr,
  input  logic [TOR_W-1:0] tor_wdata,
  input  logic             baud_tick,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [3:0]       line_err,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             msr_rd,
  input  logic             cts,
  input  logic             dsr,
  input  logic             ri,
  input  logic             dcd,
  output logic [3:0]       iir_code,
  output logic             irq,
  output logic [3:0]       modem_delta,
  output logic             rx_fifo_clr,
  output logic             tx_fifo_clr,
  output logic             dma_sel
);

  localparam int unsigned TRIG_W = 4;
  localparam int unsigned TRIG_LO = 4;
  localparam int unsigned CMP_W  = (LVL_W > TRIG_W) ? LVL_W : TRIG_W;

  // Control state
  logic [TRIG_W-1:0] trig_q, trig_d;
  logic [TOR_W-1:0]  idle_q, idle_d;
  logic              dma_q, dma_d;

  // Latched sources
  logic              le_q, le_d;
  logic              he_q, he_d;
  logic              thr_empty_q;

  logic [CMP_W-1:0]  thresh;
  logic [CMP_W-1:0]  lvl_ext;
  logic              da_pend;
  logic              to_pend;
  logic              ms_pend;
  logic              he_rise;
  logic              he_reported;
  logic              fifo_on;

  logic [NSRC-1:0]   pend_v;
  logic [NSRC-1:0]   en_v;

  // FIFO control decode
  assign fifo_on     = fcr_wdata[0];
  assign rx_fifo_clr = fcr_wr & (fcr_wdata[1] | ~fifo_on);
  assign tx_fifo_clr = fcr_wr & (fcr_wdata[2] | ~fifo_on);

  always_comb begin
    trig_d = trig_q;
    dma_d  = dma_q;
    idle_d = idle_q;
    if (fcr_wr) begin
      trig_d = fcr_wdata[TRIG_LO +: TRIG_W];
      dma_d  = fcr_wdata[3];
    end
    if (tor_wr) begin
      idle_d = tor_wdata;
    end
  end

  // Data-available compare
  assign thresh  = (trig_q == '0) ? CMP_W'(1) : CMP_W'(trig_q);
  assign lvl_ext = CMP_W'(rx_level);
  assign da_pend = (lvl_ext >= thresh);

  // Line error latch: new error beats a clearing read
  always_comb begin
    if (|line_err) begin
      le_d = 1'b1;
    end else if (lsr_rd) begin
      le_d = 1'b0;
    end else begin
      le_d = le_q;
    end
  end

  // Holding-empty latch: clears beat a coincident edge
  assign he_rise = thr_empty & ~thr_empty_q;

  always_comb begin
    if (thr_wr || (iir_rd && he_reported)) begin
      he_d = 1'b0;
    end else if (he_rise) begin
      he_d = 1'b1;
    end else begin
      he_d = he_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q      <= '0;
      idle_q      <= '0;
      dma_q       <= 1'b0;
      le_q        <= 1'b0;
      he_q        <= 1'b0;
      thr_empty_q <= 1'b0;
    end else begin
      trig_q      <= trig_d;
      idle_q      <= idle_d;
      dma_q       <= dma_d;
      le_q        <= le_d;
      he_q        <= he_d;
      thr_empty_q <= thr_empty;
    end
  end

  assign dma_sel = dma_q;

  uart_irq_rx_timeout #(
    .LVL_W (LVL_W),
    .TOR_W (TOR_W)
  ) u_tout (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rbr_rd    (rbr_rd),
    .idle_len  (idle_q),
    .tout      (to_pend)
  );

  uart_irq_modem_delta #(
    .NLINE     (4),
    .FALL_ONLY (4'b0100)
  ) u_modem (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in ({dcd, ri, dsr, cts}),
    .msr_rd  (msr_rd),
    .delta   (modem_delta)
  );

  assign ms_pend = |modem_delta;

  always_comb begin
    pend_v          = '0;
    en_v            = '0;
    pend_v[SLOT_LE] = le_q;
    pend_v[SLOT_DA] = da_pend;
    pend_v[SLOT_TO] = to_pend;
    pend_v[SLOT_HE] = he_q;
    pend_v[SLOT_MS] = ms_pend;
    en_v[SLOT_LE]   = ien[2];
    en_v[SLOT_DA]   = ien[0];
    en_v[SLOT_TO]   = ien[0];
    en_v[SLOT_HE]   = ien[1];
    en_v[SLOT_MS]   = ien[3];
  end

  uart_irq_arbiter u_arb (
    .pend        (pend_v),
    .enable      (en_v),
    .id_code     (iir_code),
    .req         (irq),
    .he_reported (he_reported)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ien,
  input logic             fcr_wr,
  input logic [3:0]       line_err,
  input logic             lsr_rd,
  input logic [LVL_W-1:0] rx_level,
  input logic             iir_rd,
  input logic             msr_rd,
  input logic [3:0]       iir_code,
  input logic             irq,
  input logic [3:0]       modem_delta,
  input logic             rx_fifo_clr,
  input logic             tx_fifo_clr
);

  p_irq_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_code != 4'b0001));

  p_le_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err != 4'b0000) |=> (!ien[2] || iir_code == 4'b0110));

  p_le_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && line_err == 4'b0000) |=> (iir_code != 4'b0110));

  p_tout_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> (iir_code != 4'b1100));

  p_he_id_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_code == 4'b0010) |=> (iir_code != 4'b0010));

  p_delta_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_rd |=> ((modem_delta & $past(modem_delta)) == $past(modem_delta)));

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'b0000) |-> !irq);

  p_fifo_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_clr || tx_fifo_clr) |-> fcr_wr);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ien         (ien),
  .fcr_wr      (fcr_wr),
  .line_err    (line_err),
  .lsr_rd      (lsr_rd),
  .rx_level    (rx_level),
  .iir_rd      (iir_rd),
  .msr_rd      (msr_rd),
  .iir_code    (iir_code),
  .irq         (irq),
  .modem_delta (modem_delta),
  .rx_fifo_clr (rx_fifo_clr),
  .tx_fifo_clr (tx_fifo_clr)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;
  localparam int TOR_W = 8;

  logic             clk;
  logic             rst_n;
  logic [3:0]       ien;
  logic             fcr_wr;
  logic [7:0]       fcr_wdata;
  logic             tor_wr;
  logic [TOR_W-1:0] tor_wdata;
  logic             baud_tick;
  logic [LVL_W-1:0] rx_level;
  logic             rx_push;
  logic             rx_pop;
  logic [3:0]       line_err;
  logic             lsr_rd;
  logic             rbr_rd;
  logic             thr_empty;
  logic             thr_wr;
  logic             iir_rd;
  logic             msr_rd;
  logic             cts, dsr, ri, dcd;
  logic [3:0]       iir_code;
  logic             irq;
  logic [3:0]       modem_delta;
  logic             rx_fifo_clr;
  logic             tx_fifo_clr;
  logic             dma_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_irq_ident #(.LVL_W(LVL_W), .TOR_W(TOR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ien(ien), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .tor_wr(tor_wr), .tor_wdata(tor_wdata), .baud_tick(baud_tick),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .line_err(line_err), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .iir_rd(iir_rd), .msr_rd(msr_rd),
    .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd),
    .iir_code(iir_code), .irq(irq), .modem_delta(modem_delta),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .dma_sel(dma_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare code and request line together (R2 holds in every code check)
  task automatic chk_id(input logic [3:0] exp, input string tag);
    chk(iir_code == exp, tag, iir_code, exp);
    chk(irq == (exp != 4'b0001), {tag, " R2 irq"}, irq, exp != 4'b0001);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    baud_tick = 1'b1; step();
    baud_tick = 1'b0; step();
  endtask

  function automatic logic [3:0] mask_expect(input logic [3:0] m);
    if (m[2]) return 4'b0110;
    if (m[0]) return 4'b0100;
    if (m[1]) return 4'b0010;
    if (m[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ien = 4'h0; fcr_wr = 1'b0; fcr_wdata = 8'h00;
    tor_wr = 1'b0; tor_wdata = '0; baud_tick = 1'b0; rx_level = '0;
    rx_push = 1'b0; rx_pop = 1'b0; line_err = 4'h0; lsr_rd = 1'b0;
    rbr_rd = 1'b0; thr_empty = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0;
    msr_rd = 1'b0; cts = 1'b0; dsr = 1'b0; ri = 1'b0; dcd = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    ien = 4'hF;
    step();

    // R1 reset state
    chk_id(4'b0001, "R1 reset code");
    chk(modem_delta == 4'h0, "R1 reset delta", modem_delta, 0);
    chk(dma_sel == 1'b0, "R1 reset dma", dma_sel, 0);

    // R3 each error kind latches and lsr_rd clears
    ien = 4'b0100;
    for (int b = 0; b < 4; b++) begin
      line_err = 4'(1 << b); step();
      line_err = 4'h0;
      chk_id(4'b0110, "R3 error latch");
      step();
      chk_id(4'b0110, "R3 error held");
      lsr_rd = 1'b1; step();
      lsr_rd = 1'b0;
      chk_id(4'b0001, "R3 lsr_rd clear");
    end

    // R4 / R9 trigger code x fill level sweep
    ien = 4'b0001;
    for (int code = 0; code < 16; code++) begin
      fcr_wr = 1'b1;
      fcr_wdata = {4'(code), 1'(code & 1), 1'((code >> 1) & 1), 1'((code >> 2) & 1), 1'b1};
      #1;
      chk(rx_fifo_clr == 1'((code >> 2) & 1), "R9 rx clear", rx_fifo_clr, (code >> 2) & 1);
      chk(tx_fifo_clr == 1'((code >> 1) & 1), "R9 tx clear", tx_fifo_clr, (code >> 1) & 1);
      step();
      fcr_wr = 1'b0;
      chk(dma_sel == 1'(code & 1), "R9 dma select", dma_sel, code & 1);
      for (int lvl = 0; lvl <= 16; lvl++) begin
        int thr;
        thr = (code == 0) ? 1 : code;
        rx_level = LVL_W'(lvl);
        #1;
        chk_id((lvl >= thr) ? 4'b0100 : 4'b0001, "R4 level vs threshold");
      end
      rx_level = '0;
      step();
    end
    // R9 FIFO-enable bit clear resets both
    fcr_wr = 1'b1; fcr_wdata = 8'h80; #1;
    chk(rx_fifo_clr && tx_fifo_clr, "R9 enable-off clears", {rx_fifo_clr, tx_fifo_clr}, 3);
    step();
    fcr_wr = 1'b0;

    // R5 exact idle durations (threshold 8 keeps data-available quiet)
    for (int t = 1; t <= 6; t++) begin
      tor_wr = 1'b1; tor_wdata = TOR_W'(t); step();
      tor_wr = 1'b0;
      rx_level = 5'd1; rx_push = 1'b1; step();
      rx_push = 1'b0;
      for (int k = 1; k < t; k++) tick();
      chk_id(4'b0001, "R5 before last tick");
      tick();
      chk_id(4'b1100, "R5 timeout after T ticks");
      rbr_rd = 1'b1; step();
      rbr_rd = 1'b0;
      chk_id(4'b0001, "R5 rbr_rd clears");
      rx_level = '0; step();
    end

    // R5 activity restarts the count; R10 data-available over timeout
    tor_wr = 1'b1; tor_wdata = 8'd4; step();
    tor_wr = 1'b0;
    rx_level = 5'd2; rx_push = 1'b1; step();
    rx_push = 1'b0;
    repeat (3) tick();
    rx_pop = 1'b1; step();
    rx_pop = 1'b0;
    repeat (3) tick();
    chk_id(4'b0001, "R5 restart after pop");
    tick();
    chk_id(4'b1100, "R5 timeout after restart");
    rx_level = 5'd8; #1;
    chk_id(4'b0100, "R10 data-available beats timeout");
    rx_level = 5'd1; #1;
    chk_id(4'b1100, "R10 timeout visible again");
    rx_level = '0; step();
    chk_id(4'b0001, "R5 empty clears timeout");

    // R5 zero duration disables
    tor_wr = 1'b1; tor_wdata = '0; step();
    tor_wr = 1'b0;
    rx_level = 5'd1; rx_push = 1'b1; step();
    rx_push = 1'b0;
    repeat (260) tick();
    chk_id(4'b0001, "R5 zero duration disabled");
    rx_level = '0; step();

    // R6 holding-empty source
    ien = 4'b0010;
    thr_empty = 1'b1; step();
    chk_id(4'b0010, "R6 rising edge latches");
    iir_rd = 1'b1; step();
    iir_rd = 1'b0;
    chk_id(4'b0001, "R6 id read clears");
    step();
    chk_id(4'b0001, "R6 no re-latch while level high");
    thr_empty = 1'b0; step();
    thr_empty = 1'b1; step();
    chk_id(4'b0010, "R6 second edge");
    thr_wr = 1'b1; thr_empty = 1'b0; step();
    thr_wr = 1'b0;
    chk_id(4'b0001, "R6 thr_wr clears");
    ien = 4'b0110;
    thr_empty = 1'b1; line_err = 4'h2; step();
    line_err = 4'h0;
    chk_id(4'b0110, "R10 error over holding-empty");
    iir_rd = 1'b1; step();
    iir_rd = 1'b0;
    lsr_rd = 1'b1; step();
    lsr_rd = 1'b0;
    chk_id(4'b0010, "R6 id read while not reported keeps it");
    thr_wr = 1'b1; thr_empty = 1'b0; step();
    thr_wr = 1'b0;

    // R7 modem deltas
    ien = 4'b1000;
    for (int b = 0; b < 4; b++) begin
      for (int lv = 1; lv >= 0; lv--) begin
        logic [3:0] exp_d;
        case (b)
          0: cts = 1'(lv);
          1: dsr = 1'(lv);
          2: ri  = 1'(lv);
          default: dcd = 1'(lv);
        endcase
        step();
        exp_d = (b == 2 && lv == 1) ? 4'h0 : 4'(1 << b);
        chk(modem_delta == exp_d, "R7 delta bit", modem_delta, exp_d);
        chk_id((exp_d != 0) ? 4'b0000 : 4'b0001, "R7 modem code");
        step();
        chk(modem_delta == exp_d, "R7 delta held", modem_delta, exp_d);
        msr_rd = 1'b1; step();
        msr_rd = 1'b0;
        chk(modem_delta == 4'h0, "R7 msr_rd clears", modem_delta, 0);
      end
    end

    // R8 / R10 enable mask sweep with four sources pending
    ien = 4'h0;
    line_err = 4'h1; thr_empty = 1'b1; cts = 1'b1; step();
    line_err = 4'h0;
    rx_level = 5'd8;
    for (int m = 0; m < 16; m++) begin
      ien = 4'(m); #1;
      chk_id(mask_expect(4'(m)), "R8 mask sweep");
    end
    ien = 4'h0; #1;
    chk(irq == 1'b0, "R8 all masked", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule